// File: doc/BRIEF.md
# Bus Hold Request Responder

This block sits on the processor side of a shared system bus. An external master asks for the bus by raising `hold_req`, a level that may change at any time. The request passes through a flop synchroniser and is then sampled at the falling clock edge, in the middle of the cycle. The responder can therefore take the bus away partway through an instruction; it does not wait for an instruction boundary. Once it recognises the request, it turns off the address, data and control drivers and raises `core_stall` to freeze the instruction pipeline. After a fixed latency it raises `hold_ack`.

When the request goes away, the same latency runs in reverse. `hold_ack` drops first, and the bus drivers come back one clock later, so the processor and the external master never drive the bus in the same cycle. Interrupt strobes that arrive during a hold are latched as pending. They are only taken at an instruction end while the core is not stalled, with the non-maskable request ahead of the maskable one. A synchronous reset outranks everything: it ends any hold at once, clears the pending requests and restarts the synchroniser.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are: all three driver enables 1, `hold_ack` 0, `core_stall` 0, `nmi_take` 0 and `intr_take` 0.
- R2: With the default of 2 synchroniser stages, a rise of `hold_req` clears all three driver enables and sets `core_stall` on the 3rd rising edge after the rise. In general this is edge SYNC_STAGES+1.
- R3: `hold_ack` rises ACK_LAT rising edges after the drivers turn off (default 2). It is never high while any driver enable is 1.
- R4: `hold_ack` stays high for as long as `hold_req` stays high.
- R5: When `hold_req` falls, `hold_ack` falls on rising edge SYNC_STAGES+1+ACK_LAT after the fall. The driver enables return to 1 and `core_stall` returns to 0 exactly one edge after `hold_ack` falls.
- R6: `core_stall` is 1 in every cycle where a driver enable is 0 or `hold_ack` is 1.
- R7: A one-cycle strobe on `nmi_req` or `intr_req` marks that request as pending. A pending request is taken as a one-cycle pulse on `nmi_take` or `intr_take`, registered on the first rising edge where `instr_end` is 1 and `core_stall` is 0. No take happens while stalled or without `instr_end`, and a taken request is no longer pending.
- R8: At most one take happens per edge. When both requests are pending, the NMI is taken first and the INTR on the next boundary.
- R9: Reset during a hold drops `hold_ack`, restores the drivers and discards pending requests on the next edge. If `hold_req` is still high when reset ends, a fresh entry sequence begins with the R2 timing measured from reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Asynchronous bus request from the external master |
| intr_req | input | 1 | Maskable interrupt request strobe |
| nmi_req | input | 1 | Non-maskable interrupt request strobe |
| instr_end | input | 1 | Core reports an instruction boundary this cycle |
| addr_oe | output | 1 | Address bus driver enable |
| data_oe | output | 1 | Data bus driver enable |
| ctrl_oe | output | 1 | Control bus driver enable |
| hold_ack | output | 1 | Bus grant acknowledge to the external master |
| core_stall | output | 1 | Freezes the instruction pipeline |
| intr_take | output | 1 | One-cycle pulse: maskable interrupt accepted |
| nmi_take | output | 1 | One-cycle pulse: non-maskable interrupt accepted |

## Verification
The hold handshake is driven as a clean raise followed by a clean drop. The bench checks the outputs one edge before and exactly on each expected transition, which separates an extra or missing pipeline stage from correct timing. The hold is also raised while reset is active, and reset is asserted in the middle of a grant; these two cases show that reset wins over hold. Interrupt strobes are sent while running, while held, and as an NMI and INTR pair in the same cycle. These cases separate a correct boundary gate from one that ignores the stall, and check priority order and that a pending request is cleared once taken.

// File: rtl/bus_hold_pkg.sv
`timescale 1ns/1ps
package bus_hold_pkg;

    typedef enum logic [2:0] {
        ST_RUN,       // processor owns the bus
        ST_FLOAT,     // drivers off, waiting to acknowledge
        ST_GRANT,     // acknowledge high, external master owns the bus
        ST_RETIRE,    // request gone, acknowledge still high during latency
        ST_HANDBACK   // acknowledge low, drivers still off for one cycle
    } hold_state_e;

    typedef struct packed {
        logic addr;
        logic data;
        logic ctrl;
    } bus_drive_t;

    localparam bus_drive_t DRIVE_ALL  = '{addr: 1'b1, data: 1'b1, ctrl: 1'b1};
    localparam bus_drive_t DRIVE_NONE = '{addr: 1'b0, data: 1'b0, ctrl: 1'b0};

    function automatic logic state_owns_bus(hold_state_e s);
        return s == ST_RUN;
    endfunction

    function automatic logic state_acks(hold_state_e s);
        return (s == ST_GRANT) || (s == ST_RETIRE);
    endfunction

endpackage

// File: rtl/bus_hold_sync.sv
`timescale 1ns/1ps
module bus_hold_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic req_mid
);
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= req_async;
    end

    for (genvar st = 1; st < SYNC_STAGES; st++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[st] <= 1'b0;
            else     chain[st] <= chain[st-1];
        end
    end

    // sample point in the middle of the cycle
    always_ff @(negedge clk) begin
        if (rst) req_mid <= 1'b0;
        else     req_mid <= chain[SYNC_STAGES-1];
    end
endmodule

// File: rtl/bus_hold_seq.sv
`timescale 1ns/1ps
module bus_hold_seq
    import bus_hold_pkg::*;
#(
    parameter int ACK_LAT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_seen,
    output bus_drive_t drive,
    output logic       ack,
    output logic       stall
);
    localparam int CW = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1;
    localparam logic [CW-1:0] LOAD = CW'(ACK_LAT - 1);

    hold_state_e   state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            case (state)
                ST_RUN: if (hold_seen) begin
                    state <= ST_FLOAT;
                    cnt   <= LOAD;
                end
                ST_FLOAT: begin
                    if (cnt == '0) state <= ST_GRANT;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_GRANT: if (!hold_seen) begin
                    state <= ST_RETIRE;
                    cnt   <= LOAD;
                end
                ST_RETIRE: begin
                    if (cnt == '0) state <= ST_HANDBACK;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_HANDBACK: state <= ST_RUN;
                default:     state <= ST_RUN;
            endcase
        end
    end

    assign drive = state_owns_bus(state) ? DRIVE_ALL : DRIVE_NONE;
    assign ack   = state_acks(state);
    assign stall = !state_owns_bus(state);

    // acknowledge only ever rises out of the floating phase
    assert_ack_after_float_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(state == ST_FLOAT));

    // drivers only return after a cycle with acknowledge low
    assert_handback_gap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(drive.addr) |-> ($past(!ack) && $past(!drive.addr)));
endmodule

// File: rtl/bus_hold_irq_gate.sv
`timescale 1ns/1ps
module bus_hold_irq_gate (
    input  logic clk,
    input  logic rst,
    input  logic nmi_strobe,
    input  logic intr_strobe,
    input  logic instr_end,
    input  logic stall,
    output logic nmi_take,
    output logic intr_take
);
    logic nmi_pend, intr_pend;
    logic boundary, grab_nmi, grab_intr;

    assign boundary  = instr_end && !stall;
    assign grab_nmi  = boundary && nmi_pend;
    assign grab_intr = boundary && intr_pend && !nmi_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_pend  <= 1'b0;
            intr_pend <= 1'b0;
            nmi_take  <= 1'b0;
            intr_take <= 1'b0;
        end else begin
            nmi_pend  <= (nmi_pend  && !grab_nmi)  || nmi_strobe;
            intr_pend <= (intr_pend && !grab_intr) || intr_strobe;
            nmi_take  <= grab_nmi;
            intr_take <= grab_intr;
        end
    end

    assert_take_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        (nmi_take || intr_take) |-> $past(instr_end && !stall));

    assert_single_take_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nmi_take, intr_take}));
endmodule

// File: rtl/bus_hold_ctrl.sv
`timescale 1ns/1ps
module bus_hold_ctrl
    import bus_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ACK_LAT     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_req,
    input  logic intr_req,
    input  logic nmi_req,
    input  logic instr_end,
    output logic addr_oe,
    output logic data_oe,
    output logic ctrl_oe,
    output logic hold_ack,
    output logic core_stall,
    output logic intr_take,
    output logic nmi_take
);
    logic       hold_seen;
    bus_drive_t drive;

    bus_hold_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .req_async (hold_req),
        .req_mid   (hold_seen)
    );

    bus_hold_seq #(.ACK_LAT(ACK_LAT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .hold_seen (hold_seen),
        .drive     (drive),
        .ack       (hold_ack),
        .stall     (core_stall)
    );

    bus_hold_irq_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .nmi_strobe  (nmi_req),
        .intr_strobe (intr_req),
        .instr_end   (instr_end),
        .stall       (core_stall),
        .nmi_take    (nmi_take),
        .intr_take   (intr_take)
    );

    assign addr_oe = drive.addr;
    assign data_oe = drive.data;
    assign ctrl_oe = drive.ctrl;

    assert_ack_floated_R3: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> !(addr_oe || data_oe || ctrl_oe));

    assert_stall_cover_R6: assert property (@(posedge clk) disable iff (rst)
        (hold_ack || !addr_oe || !data_oe || !ctrl_oe) |-> core_stall);

    assert_reset_wins_R9: assert property (@(posedge clk)
        $past(rst) |-> (!hold_ack && addr_oe && !nmi_take && !intr_take));
endmodule

// File: tb/bus_hold_ctrl_bench.sv
`timescale 1ns/1ps
module bus_hold_ctrl_bench;
    localparam int SYNC = 2;
    localparam int LAT  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_req = 1'b0, intr_req = 1'b0, nmi_req = 1'b0, instr_end = 1'b0;
    logic addr_oe, data_oe, ctrl_oe, hold_ack, core_stall, intr_take, nmi_take;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_hold_ctrl #(.SYNC_STAGES(SYNC), .ACK_LAT(LAT)) u_bus_hold_ctrl (
        .clk(clk), .rst(rst), .hold_req(hold_req), .intr_req(intr_req),
        .nmi_req(nmi_req), .instr_end(instr_end), .addr_oe(addr_oe),
        .data_oe(data_oe), .ctrl_oe(ctrl_oe), .hold_ack(hold_ack),
        .core_stall(core_stall), .intr_take(intr_take), .nmi_take(nmi_take)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic enter_hold();
        hold_req = 1'b1;
        step(SYNC + 1 + LAT);
    endtask

    task automatic leave_hold();
        hold_req = 1'b0;
        step(SYNC + LAT + 2);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        hold_req = 1'b1;
        step(3);
        chk("R1 ack in reset", hold_ack, 0);
        chk("R1 drivers in reset", {addr_oe, data_oe, ctrl_oe}, 7);
        chk("R1 stall in reset", core_stall, 0);
        chk("R1 takes in reset", {nmi_take, intr_take}, 0);
        hold_req = 1'b0;
        rst = 1'b0;
        step(SYNC + 2);
        chk("R9 no hold after reset", {addr_oe, hold_ack}, 2);
    endtask

    task automatic t_enter();
        hold_req = 1'b1;
        step(SYNC);
        chk("R2 drivers still on", addr_oe, 1);
        step(1);
        chk("R2 drivers float", {addr_oe, data_oe, ctrl_oe}, 0);
        chk("R6 stall at float", core_stall, 1);
        chk("R3 ack not yet", hold_ack, 0);
        step(LAT - 1);
        chk("R3 ack one early", hold_ack, 0);
        step(1);
        chk("R3 ack raised", hold_ack, 1);
        step(5);
        chk("R4 ack held", hold_ack, 1);
        chk("R6 stall held", core_stall, 1);
    endtask

    task automatic t_exit();
        hold_req = 1'b0;
        step(SYNC + LAT);
        chk("R5 ack still high", hold_ack, 1);
        step(1);
        chk("R5 ack dropped", hold_ack, 0);
        chk("R5 drivers still off", addr_oe, 0);
        chk("R6 stall in handback", core_stall, 1);
        step(1);
        chk("R5 drivers back", {addr_oe, data_oe, ctrl_oe}, 7);
        chk("R5 stall released", core_stall, 0);
    endtask

    task automatic t_irq_run();
        intr_req = 1'b1;
        step(1);
        intr_req = 1'b0;
        step(2);
        chk("R7 no take without boundary", intr_take, 0);
        instr_end = 1'b1;
        step(1);
        chk("R7 intr taken", intr_take, 1);
        step(1);
        chk("R7 pending cleared", intr_take, 0);
        instr_end = 1'b0;
    endtask

    task automatic t_irq_held();
        enter_hold();
        nmi_req = 1'b1;
        step(1);
        nmi_req = 1'b0;
        instr_end = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1);
            chk("R7 no take while stalled", nmi_take, 0);
        end
        instr_end = 1'b0;
        leave_hold();
        instr_end = 1'b1;
        step(1);
        chk("R7 nmi taken after hold", nmi_take, 1);
        instr_end = 1'b0;
        step(1);
    endtask

    task automatic t_priority();
        nmi_req = 1'b1;
        intr_req = 1'b1;
        step(1);
        nmi_req = 1'b0;
        intr_req = 1'b0;
        instr_end = 1'b1;
        step(1);
        chk("R8 nmi first", {nmi_take, intr_take}, 2);
        step(1);
        chk("R8 intr second", {nmi_take, intr_take}, 1);
        step(1);
        chk("R8 nothing left", {nmi_take, intr_take}, 0);
        instr_end = 1'b0;
    endtask

    task automatic t_reset_hold();
        enter_hold();
        chk("R4 granted before reset", hold_ack, 1);
        nmi_req = 1'b1;
        step(1);
        nmi_req = 1'b0;
        rst = 1'b1;
        step(1);
        chk("R9 ack cleared", hold_ack, 0);
        chk("R9 drivers restored", {addr_oe, data_oe, ctrl_oe}, 7);
        chk("R9 stall cleared", core_stall, 0);
        step(2);
        rst = 1'b0;
        step(SYNC);
        chk("R9 fresh entry not early", addr_oe, 1);
        step(1);
        chk("R9 fresh entry floats", addr_oe, 0);
        step(LAT);
        chk("R9 fresh entry ack", hold_ack, 1);
        leave_hold();
        instr_end = 1'b1;
        step(1);
        chk("R9 pending discarded", nmi_take, 0);
        instr_end = 1'b0;
        step(1);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_enter();
        t_exit();
        t_irq_run();
        t_irq_held();
        t_priority();
        t_reset_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule